// File: doc/BRIEF.md
# PWM Prescaler Tick Generator

This block derives the time base for a multi-channel PWM unit from one master clock. A free-running binary counter yields eleven power-of-two tick streams: the master rate divided by 1, 2, 4 and so on up to 1024. Two independent linear dividers, A and B, each pick one of those streams and divide it again by a programmable 8-bit value. All outputs are single-cycle enable pulses in the master clock domain. Channel logic uses them as clock enables; no derived clock is ever gated.

Software-side logic programs a divider through a narrow write port. It presents a divider index, a 4-bit stream select and an 8-bit divide value for one cycle. A divide value of zero, or a select that names no stream, parks that divider with its output low. A global run input stands for the master clock being stopped. While run is low every output is low and every counter holds its value.

Top module: `pwm_tickgen`

## Requirements
- R1: While `run_en` is high, `tap_tick[k]` (k = 0..10) is high exactly on the cycles where the number of enabled cycles since reset, modulo 2^k, equals 2^k - 1. A pulse on tap k therefore implies a pulse on every lower tap, and tap 0 is high on every enabled cycle.
- R2: On the first cycle after reset is released, with `run_en` high, `tap_tick` equals 11'b1 and both `lin_tick` bits are low. Until the first write, both dividers stay off because their divide values reset to 0 and their selects reset to 0.
- R3: With stream select s (0..10) and divide value N (1..255), the divider output pulses on every N-th pulse of `tap_tick[s]`. Divider A drives `lin_tick[0]` and divider B drives `lin_tick[1]`.
- R4: A divide value of 0 holds that divider's output low for as long as the setting stands.
- R5: A stream select of 11 to 15 holds that divider's output low for as long as the setting stands.
- R6: A write (`wr_en` high, `wr_sel` = 0 for A or 1 for B) takes effect from the next cycle and restarts that divider's count from zero. The first new pulse then falls on the N-th selected-stream pulse counted from that next cycle. The cycle that carries the write still runs under the old setting.
- R7: While `run_en` is low, all `tap_tick` and `lin_tick` bits are low and the prescaler and divider counts hold. When `run_en` returns high, counting resumes where it stopped.
- R8: The two dividers keep separate settings and counts, so a write to one leaves the other's pulse train unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Master clock running; low freezes and silences the block |
| wr_en | input | 1 | Write strobe for one divider setting |
| wr_sel | input | 1 | Divider index: 0 = A, 1 = B |
| wr_src | input | 4 | Prescaler stream select; 0..10 valid |
| wr_div | input | 8 | Linear divide value; 0 = off |
| tap_tick | output | 11 | Prescaler pulses, bit k = master / 2^k |
| lin_tick | output | 2 | Linear divider pulses, bit 0 = A, bit 1 = B |

## Verification
The dividers are tried with several source patterns:
- Stream 0 with divide 1 shows that every master cycle passes through.
- A mid-range stream with divide 5 shows how the source and linear counts combine.
- Stream 10 with divide 2 and stream 2 with divide 255 exercise the widest intervals.

Divide value 0 and out-of-range selects 12 and 15 must produce silence. An immediate rewrite of the same setting separates a restarting counter from one that carries on. A run-low gap in the middle of a count shows whether the counts freeze or are lost. Running both dividers on different streams at once exposes any crosstalk between them.

// File: rtl/pwm_tickgen_pkg.sv
package pwm_tickgen_pkg;

    // Default geometry of the tick generator
    localparam int DEF_TAP_N = 11;   // prescaler streams: /1 .. /1024
    localparam int DEF_DIV_W = 8;    // linear divide value width
    localparam int DEF_LIN_N = 2;    // number of linear dividers

    // Index of each linear divider on the write port and output vector
    typedef enum logic [0:0] {
        LIN_A = 1'b0,
        LIN_B = 1'b1
    } lin_id_e;

    // Width needed to index n items, never below 1
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tickgen_prescaler.sv
module tickgen_prescaler #(
    parameter int TAP_N = pwm_tickgen_pkg::DEF_TAP_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    output logic [TAP_N-1:0] tap_tick
);
    localparam int CNT_W = TAP_N - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Stream k fires when the low k bits of the count are all ones
    for (genvar k = 0; k < TAP_N; k++) begin : g_tap
        if (k == 0) begin : g_undiv
            assign tap_tick[k] = run_en;
        end else begin : g_div
            assign tap_tick[k] = run_en & (&st_q.cnt[k-1:0]);
        end
    end

endmodule

// File: rtl/tickgen_cfg.sv
module tickgen_cfg #(
    parameter int LIN_N  = pwm_tickgen_pkg::DEF_LIN_N,
    parameter int SEL_W  = 4,
    parameter int DIV_W  = pwm_tickgen_pkg::DEF_DIV_W,
    parameter int LSEL_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [LSEL_W-1:0]           wr_sel,
    input  logic [SEL_W-1:0]            wr_src,
    input  logic [DIV_W-1:0]            wr_div,
    output logic [LIN_N-1:0][SEL_W-1:0] src_sel,
    output logic [LIN_N-1:0][DIV_W-1:0] div_val,
    output logic [LIN_N-1:0]            restart
);
    typedef struct packed {
        logic [LIN_N-1:0][SEL_W-1:0] src;
        logic [LIN_N-1:0][DIV_W-1:0] div;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        restart = '0;
        for (int i = 0; i < LIN_N; i++) begin
            if (wr_en && (wr_sel == LSEL_W'(i))) begin
                restart[i]    = 1'b1;
                st_d.src[i]   = wr_src;
                st_d.div[i]   = wr_div;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_sel = st_q.src;
    assign div_val = st_q.div;

endmodule

// File: rtl/tickgen_lindiv.sv
module tickgen_lindiv #(
    parameter int TAP_N = pwm_tickgen_pkg::DEF_TAP_N,
    parameter int SEL_W = 4,
    parameter int DIV_W = pwm_tickgen_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [TAP_N-1:0] taps,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic             restart,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    logic src_tick;
    logic div_on;
    logic at_end;
    logic advance;

    // Selects beyond the last stream never match, so they give no source
    always_comb begin
        src_tick = 1'b0;
        for (int k = 0; k < TAP_N; k++) begin
            if (src_sel == SEL_W'(k)) begin
                src_tick = taps[k];
            end
        end
    end

    assign div_on  = (div_val != '0);
    assign at_end  = (st_q.cnt >= (div_val - 1'b1));
    assign advance = run_en & div_on & src_tick;
    assign tick    = advance & at_end;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (advance) begin
            st_d.cnt = at_end ? '0 : (st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_tickgen.sv
module pwm_tickgen #(
    parameter int TAP_N = pwm_tickgen_pkg::DEF_TAP_N,
    parameter int DIV_W = pwm_tickgen_pkg::DEF_DIV_W,
    parameter int LIN_N = pwm_tickgen_pkg::DEF_LIN_N,
    parameter int SEL_W  = pwm_tickgen_pkg::idx_width(TAP_N),
    parameter int LSEL_W = pwm_tickgen_pkg::idx_width(LIN_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              wr_en,
    input  logic [LSEL_W-1:0] wr_sel,
    input  logic [SEL_W-1:0]  wr_src,
    input  logic [DIV_W-1:0]  wr_div,
    output logic [TAP_N-1:0]  tap_tick,
    output logic [LIN_N-1:0]  lin_tick
);
    logic [LIN_N-1:0][SEL_W-1:0] src_sel;
    logic [LIN_N-1:0][DIV_W-1:0] div_val;
    logic [LIN_N-1:0]            restart;

    tickgen_prescaler #(
        .TAP_N (TAP_N)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tap_tick (tap_tick)
    );

    tickgen_cfg #(
        .LIN_N  (LIN_N),
        .SEL_W  (SEL_W),
        .DIV_W  (DIV_W),
        .LSEL_W (LSEL_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_src  (wr_src),
        .wr_div  (wr_div),
        .src_sel (src_sel),
        .div_val (div_val),
        .restart (restart)
    );

    for (genvar g = 0; g < LIN_N; g++) begin : g_lin
        tickgen_lindiv #(
            .TAP_N (TAP_N),
            .SEL_W (SEL_W),
            .DIV_W (DIV_W)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_en  (run_en),
            .taps    (tap_tick),
            .src_sel (src_sel[g]),
            .div_val (div_val[g]),
            .restart (restart[g]),
            .tick    (lin_tick[g])
        );
    end

endmodule

// File: rtl/tickgen_chk.sv
module tickgen_chk #(
    parameter int TAP_N  = 11,
    parameter int DIV_W  = 8,
    parameter int LIN_N  = 2,
    parameter int SEL_W  = 4,
    parameter int LSEL_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              wr_en,
    input logic [LSEL_W-1:0] wr_sel,
    input logic [SEL_W-1:0]  wr_src,
    input logic [DIV_W-1:0]  wr_div,
    input logic [TAP_N-1:0]  tap_tick,
    input logic [LIN_N-1:0]  lin_tick
);
    // Shadow of which dividers were last written with an "off" setting
    logic [LIN_N-1:0] div_zero_q;
    logic [LIN_N-1:0] src_bad_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_zero_q <= '1;
            src_bad_q  <= '0;
        end else begin
            for (int i = 0; i < LIN_N; i++) begin
                if (wr_en && (wr_sel == LSEL_W'(i))) begin
                    div_zero_q[i] <= (wr_div == '0);
                    src_bad_q[i]  <= (int'(wr_src) >= TAP_N);
                end
            end
        end
    end

    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (((tap_tick >> 1) & ~tap_tick) == '0)); // R1

    AST_TAP1_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en) && $past(tap_tick[1])) |-> !tap_tick[1]); // R1

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lin_tick == '0 && (tap_tick >> 1) == '0)); // R2

    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (tap_tick == '0 && lin_tick == '0)); // R7

    for (genvar g = 0; g < LIN_N; g++) begin : g_lin_chk
        AST_DIV_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            div_zero_q[g] |-> !lin_tick[g]); // R4

        AST_BAD_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            src_bad_q[g] |-> !lin_tick[g]); // R5

        AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == LSEL_W'(g) && wr_div > 1) |=> !lin_tick[g]); // R6
    end

endmodule

bind pwm_tickgen tickgen_chk #(
    .TAP_N  (TAP_N),
    .DIV_W  (DIV_W),
    .LIN_N  (LIN_N),
    .SEL_W  (SEL_W),
    .LSEL_W (LSEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_src   (wr_src),
    .wr_div   (wr_div),
    .tap_tick (tap_tick),
    .lin_tick (lin_tick)
);

// File: tb/tb_pwm_tickgen.sv
module tb_pwm_tickgen;
    localparam int TAP_N = 11;

    logic        clk    = 1'b0;
    logic        rst_n  = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en  = 1'b0;
    logic [0:0]  wr_sel = 1'b0;
    logic [3:0]  wr_src = '0;
    logic [7:0]  wr_div = '0;
    logic [10:0] tap_tick;
    logic [1:0]  lin_tick;

    int    cyc    = 0;
    int    pc     = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    int    qa[$];
    int    qb[$];
    string tag_a  = "R2";
    string tag_b  = "R2";

    pwm_tickgen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_src   (wr_src),
        .wr_div   (wr_div),
        .tap_tick (tap_tick),
        .lin_tick (lin_tick)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Bench model: cycle index and enabled-cycle count since reset
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) pc <= 0;
        else if (run_en) pc <= pc + 1;
    end

    function automatic int q_size(input int s);
        return (s == 0) ? qa.size() : qb.size();
    endfunction

    function automatic int q_front(input int s);
        return (s == 0) ? qa[0] : qb[0];
    endfunction

    function automatic int q_pop(input int s);
        if (s == 0) return qa.pop_front();
        return qb.pop_front();
    endfunction

    task automatic q_push(input int s, input int c);
        if (s == 0) qa.push_back(c);
        else qb.push_back(c);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor for one divider: compare pulses against the scoreboard queue
    task automatic mon_lin(input int s, input logic t);
        string tg;
        int    f;
        tg = (s == 0) ? tag_a : tag_b;
        while (q_size(s) > 0 && q_front(s) < cyc) begin
            f = q_pop(s);
            checks++;
            errors++;
            $display("FAIL %s: divider %0d actual no pulse, expected pulse at cycle %0d", tg, s, f);
        end
        if (t) begin
            checks++;
            if (q_size(s) == 0) begin
                errors++;
                $display("FAIL %s: divider %0d actual pulse at cycle %0d, expected none", tg, s, cyc);
            end else begin
                f = q_pop(s);
                if (f != cyc) begin
                    errors++;
                    $display("FAIL %s: divider %0d actual pulse at cycle %0d, expected cycle %0d", tg, s, cyc, f);
                end
            end
        end
    endtask

    always @(negedge clk) begin
        logic [10:0] exp_t;
        if (rst_n && !done) begin
            for (int k = 0; k < TAP_N; k++) begin
                exp_t[k] = run_en && ((pc % (1 << k)) == ((1 << k) - 1));
            end
            checks++;
            if (tap_tick !== exp_t) begin
                errors++;
                $display("FAIL %s: tap_tick actual %b, expected %b (cycle %0d)",
                         run_en ? "R1" : "R7", tap_tick, exp_t, cyc);
            end
            mon_lin(0, lin_tick[0]);
            mon_lin(1, lin_tick[1]);
        end
    end

    // Driver: present one write, then push the pulses it must produce
    // over cycles [base, base+len], assuming run_en stays high.
    task automatic write_cfg(input int s, input int src, input int dv, input int len);
        int base;
        int bpc;
        int cnt;
        int per;
        wr_en  = 1'b1;
        wr_sel = 1'(s);
        wr_src = 4'(src);
        wr_div = 8'(dv);
        step();
        wr_en  = 1'b0;
        base   = cyc;
        bpc    = pc;
        cnt    = 0;
        if (dv != 0 && src < TAP_N) begin
            per = 1 << src;
            for (int c = base; c <= base + len; c++) begin
                if (((bpc + c - base) % per) == per - 1) begin
                    cnt++;
                    if (cnt == dv) begin
                        cnt = 0;
                        q_push(s, c);
                    end
                end
            end
        end
    endtask

    task automatic drain_check(input string tg);
        checks++;
        if (qa.size() != 0 || qb.size() != 0) begin
            errors++;
            $display("FAIL %s: pending pulses actual %0d/%0d, expected 0/0", tg, qa.size(), qb.size());
            qa.delete();
            qb.delete();
        end
    endtask

    task automatic run_one(input string tg, input int s, input int src, input int dv, input int len);
        if (s == 0) tag_a = tg;
        else tag_b = tg;
        write_cfg(s, src, dv, len);
        repeat (len) step();
        write_cfg(s, 0, 0, 0);
        drain_check(tg);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        int b;
        run_en = 1'b1;
        repeat (5) step();
        rst_n = 1'b1;
        @(negedge clk);
        checks++;  // R2 reset state
        if (tap_tick !== 11'b1 || lin_tick !== 2'b00) begin
            errors++;
            $display("FAIL R2: reset state actual taps %b lin %b, expected 00000000001 00", tap_tick, lin_tick);
        end
        step();

        // R2: dividers off by default, any pulse is unexpected
        repeat (60) step();
        drain_check("R2");

        // R3: several source/divide patterns
        run_one("R3", 0, 0, 1, 20);
        run_one("R3", 0, 3, 5, 200);
        run_one("R3", 1, 10, 2, 4600);
        run_one("R3", 1, 2, 255, 1100);

        // R4: divide value zero keeps output low
        run_one("R4", 0, 1, 0, 100);
        run_one("R4", 1, 0, 0, 100);

        // R5: selects past the last stream keep output low
        run_one("R5", 0, 12, 1, 100);
        run_one("R5", 1, 15, 1, 100);

        // R6: rewrite restarts the count
        tag_a = "R6";
        write_cfg(0, 2, 4, 9);
        repeat (9) step();
        write_cfg(0, 2, 4, 60);
        repeat (60) step();
        write_cfg(0, 0, 0, 0);
        drain_check("R6");

        // R7: freeze in the middle of a count, stream 0 divide 3
        tag_a = "R7";
        write_cfg(0, 0, 3, -1);
        b = cyc;
        qa.push_back(b + 2);
        qa.push_back(b + 9);
        qa.push_back(b + 12);
        repeat (3) step();
        run_en = 1'b0;
        repeat (4) step();
        run_en = 1'b1;
        repeat (6) step();
        write_cfg(0, 0, 0, 0);
        drain_check("R7");

        // R8: both dividers at once on different streams
        tag_a = "R8";
        tag_b = "R8";
        write_cfg(0, 1, 3, 301);
        write_cfg(1, 3, 2, 301);
        repeat (300) step();
        write_cfg(0, 0, 0, 0);
        write_cfg(1, 0, 0, 0);
        drain_check("R8");

        repeat (5) step();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual run still active, expected finished");
            summary();
            $finish;
        end
    end

endmodule